// File: doc/BRIEF.md
# Repeat-Accumulate Parity Encoder

This block is a systematic encoder for a small irregular repeat-accumulate code of the low-density parity-check family. A frame of K data bits arrives one bit per cycle over a valid/ready stream. Each bit goes straight to the output stream while it is accepted. Each bit is also folded into the running sums of the checks it belongs to. Once the last data bit has been accepted, the encoder emits M parity bits on the same output stream and marks the final one with a last flag. The codeword therefore has N = K + M bits. The default of K = 12 and M = 6 keeps the 2/3 rate of a large broadcast-class code at a size that can be tested exhaustively.

Parity bit i is the XOR of the data bits attached to check i, chained with the previous parity bit: p[0] is the check-0 sum, and p[i] = p[i-1] XOR sum(check i). A single two-state accumulator produces every parity bit in turn. The connections between data bits and checks come from a parameter with one K-bit mask per check. Bit j of mask i set means data bit j feeds check i. The default table is irregular: the leading data bits feed more checks than the rest, and check 0 is smaller than the others.

Top module: `ra_parity_encoder`

## Requirements
- R1: Data bits are indexed by order of acceptance, with the first accepted bit as index 0. During the data phase, each accepted bit appears unchanged on out_bit in the same cycle, and in the same order.
- R2: Each frame on the output is exactly K data bits followed by M parity bits. out_last is high only on the M-th parity bit and is low on every other bit.
- R3: The first parity bit equals the XOR of the data bits whose positions are set in the check-0 mask.
- R4: Parity bit i (i > 0) equals parity bit i-1 XOR the XOR of the data bits set in the check-i mask. The chain restarts from zero in every frame.
- R5: in_ready is low from the acceptance of data bit K-1 until the last parity bit has been taken. No bit of the next frame is accepted before then.
- R6: While out_valid is high and out_ready is low in the parity phase, out_bit and out_last hold their values, and no parity bit is lost or repeated. In the data phase, in_ready follows out_ready, so a stalled output accepts no input.
- R7: After reset, out_valid and out_last are low while in_valid is low, in_ready equals out_ready, and the next accepted bit is data index 0 of a new frame.
- R8: With the default table, the checks hold these data indices: check 0 {0,4,8}; check 1 {1,2,5,9,10}; check 2 {0,3,4,6,11}; check 3 {1,2,5,7,8}; check 4 {0,3,6,9,10}; check 5 {1,2,3,7,11}. Data bits 0 to 3 each feed three checks and bits 4 to 11 each feed two.
- R9: With the defaults, each codeword is 18 bits long and carries 12 data bits, which is a 2/3 rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Data bit offered |
| in_ready | output | 1 | Encoder takes the offered bit this cycle |
| in_bit | input | 1 | Data bit value |
| out_valid | output | 1 | Output bit present |
| out_ready | input | 1 | Sink takes the output bit this cycle |
| out_bit | output | 1 | Codeword bit (data, then parity) |
| out_last | output | 1 | Marks the final parity bit of a frame |

## Verification
The assertions assume that in_valid and out_ready are driven to known levels from the first cycle after reset. They only require output values to hold during parity-phase stalls, because in the data phase the output is the source's own bit and the source is free to change it. The bench drives every input away from the clock edge and randomises valid and ready independently. It also withdraws data mid-frame and stalls the sink across the phase boundary and across the last parity bit, so that the hold and ordering properties meet their corner cases.

// File: rtl/ra_enc_pkg.sv
// Shared types for the repeat-accumulate parity encoder.
// Assumes nothing beyond a single clock domain.
package ra_enc_pkg;
    // Frame phase: data bits pass through, then parity bits are emitted.
    typedef enum logic {
        PH_DATA   = 1'b0,
        PH_PARITY = 1'b1
    } enc_phase_t;
endpackage

// File: rtl/ra_frame_seq.sv
// Frame sequencer: counts accepted data bits and emitted parity bits and
// switches between the data and parity phases.
// Assumes in_valid and out_ready are known after reset.
module ra_frame_seq
    import ra_enc_pkg::*;
#(
    parameter int K = 12,
    parameter int M = 6,
    localparam int DW = (K > 1) ? $clog2(K) : 1,
    localparam int PW = (M > 1) ? $clog2(M) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          out_ready,
    output enc_phase_t    phase,
    output logic [DW-1:0] data_idx,
    output logic [PW-1:0] par_idx,
    output logic          data_fire,
    output logic          par_fire,
    output logic          frame_done
);

    // Handshake qualifiers for each phase.
    always_comb begin
        data_fire  = (phase == PH_DATA) && in_valid && out_ready;
        par_fire   = (phase == PH_PARITY) && out_ready;
        frame_done = par_fire && (par_idx == PW'(M - 1));
    end

    // Phase and position counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_DATA;
            data_idx <= '0;
            par_idx  <= '0;
        end else if (data_fire) begin
            if (data_idx == DW'(K - 1)) begin
                data_idx <= '0;
                phase    <= PH_PARITY;
            end else begin
                data_idx <= data_idx + 1'b1;
            end
        end else if (par_fire) begin
            if (frame_done) begin
                par_idx <= '0;
                phase   <= PH_DATA;
            end else begin
                par_idx <= par_idx + 1'b1;
            end
        end
    end

    // R2: parity phase is entered only after the K-th data bit.
    assert_enter_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase == PH_PARITY) |-> ($past(data_idx) == DW'(K - 1)));

    // R5: data phase resumes only after the final parity bit.
    assert_leave_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase == PH_PARITY) |-> ($past(par_idx) == PW'(M - 1)));

    // R6: a stalled parity phase keeps its position.
    assert_parity_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PARITY && !out_ready) |=> (phase == PH_PARITY && $stable(par_idx)));

endmodule

// File: rtl/ra_check_bank.sv
// Check bank: one running XOR per check, fed by the data bits that the
// connection masks attach to it. Cleared at the end of each frame.
// Assumes data_idx < K whenever data_fire is high.
module ra_check_bank #(
    parameter int K = 12,
    parameter int M = 6,
    parameter logic [M*K-1:0] CHECK_MASKS = '0,
    localparam int DW = (K > 1) ? $clog2(K) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_fire,
    input  logic          data_bit,
    input  logic [DW-1:0] data_idx,
    input  logic          clear,
    output logic [M-1:0]  sums
);

    for (genvar g = 0; g < M; g++) begin : g_check
        localparam logic [K-1:0] ROW = CHECK_MASKS[g*K +: K];
        logic sum_q;

        // Fold the accepted bit into this check if the mask selects it.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                sum_q <= 1'b0;
            end else if (data_fire && ROW[data_idx]) begin
                sum_q <= sum_q ^ data_bit;
            end
        end

        assign sums[g] = sum_q;
    end

    // R4: every frame starts with empty check sums.
    assert_bank_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sums == '0));

    // R5: no data bit is taken in the cycle a frame closes.
    assert_fire_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_fire && clear));

endmodule

// File: rtl/ra_chain_acc.sv
// Chained accumulator: the single two-state datapath reused for every
// parity bit. Its output is the stored previous parity XOR the current
// check sum. Assumes check_sum is stable while step is low.
module ra_chain_acc (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clear,
    input  logic check_sum,
    output logic par_bit
);

    logic acc_q;

    // Current parity bit from the stored chain state.
    assign par_bit = acc_q ^ check_sum;

    // Store each emitted parity bit; restart the chain at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= 1'b0;
        end else if (step) begin
            acc_q <= par_bit;
        end
    end

    // R4: the chain starts from zero in each frame.
    assert_chain_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_q == 1'b0));

endmodule

// File: rtl/ra_parity_encoder.sv
// Systematic repeat-accumulate encoder top. Data bits pass through to the
// output while being folded into per-check sums. The chained parity bits
// follow, with out_last on the final one.
// Assumes CHECK_MASKS holds one K-bit mask per check, check i at [i*K +: K].
module ra_parity_encoder
    import ra_enc_pkg::*;
#(
    parameter int K = 12,
    parameter int M = 6,
    parameter logic [M*K-1:0] CHECK_MASKS = {12'h88E, 12'h649, 12'h1A6,
                                            12'h859, 12'h626, 12'h111},
    localparam int DW = (K > 1) ? $clog2(K) : 1,
    localparam int PW = (M > 1) ? $clog2(M) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_bit,
    output logic out_valid,
    input  logic out_ready,
    output logic out_bit,
    output logic out_last
);

    enc_phase_t    phase;
    logic [DW-1:0] data_idx;
    logic [PW-1:0] par_idx;
    logic          data_fire;
    logic          par_fire;
    logic          frame_done;
    logic [M-1:0]  sums;
    logic          sel_sum;
    logic          par_bit;

    ra_frame_seq #(.K(K), .M(M)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .out_ready  (out_ready),
        .phase      (phase),
        .data_idx   (data_idx),
        .par_idx    (par_idx),
        .data_fire  (data_fire),
        .par_fire   (par_fire),
        .frame_done (frame_done)
    );

    ra_check_bank #(.K(K), .M(M), .CHECK_MASKS(CHECK_MASKS)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_fire (data_fire),
        .data_bit  (in_bit),
        .data_idx  (data_idx),
        .clear     (frame_done),
        .sums      (sums)
    );

    // Pick the sum of the check whose parity bit is being emitted.
    assign sel_sum = sums[par_idx];

    ra_chain_acc acc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (par_fire),
        .clear     (frame_done),
        .check_sum (sel_sum),
        .par_bit   (par_bit)
    );

    // Output stream mux and input back-pressure by phase.
    always_comb begin
        if (phase == PH_DATA) begin
            in_ready  = out_ready;
            out_valid = in_valid;
            out_bit   = in_bit;
            out_last  = 1'b0;
        end else begin
            in_ready  = 1'b0;
            out_valid = 1'b1;
            out_bit   = par_bit;
            out_last  = (par_idx == PW'(M - 1));
        end
    end

    // R6: a stalled parity bit keeps its value.
    assert_stall_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && phase == PH_PARITY) |=> ($stable(out_bit) && $stable(out_last)));

    // R2: the last flag is followed by the data phase of a fresh frame.
    assert_last_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_last);

endmodule

// File: tb/ra_parity_encoder_tb.sv
// Bench for ra_parity_encoder: a behavioural frame model compared with the
// ports on every clock.
module ra_parity_encoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int K = 12;
    localparam int M = 6;
    localparam int N = K + M;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic out_ready = 1'b0;
    logic in_ready, out_valid, out_bit, out_last;

    int checks = 0;
    int failures = 0;

    // Model state.
    int emitted = 0;
    int frames = 0;
    bit dat[K];
    bit par[M];
    bit got[M];
    bit prev_stall = 1'b0;
    bit prev_bit = 1'b0;
    bit last_in_taken = 1'b0;

    // Connection lists per check, -1 pads (R8).
    int conn[M][5] = '{'{0, 4, 8, -1, -1}, '{1, 2, 5, 9, 10}, '{0, 3, 4, 6, 11},
                       '{1, 2, 5, 7, 8}, '{0, 3, 6, 9, 10}, '{1, 2, 3, 7, 11}};

    ra_parity_encoder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_bit    (in_bit),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_bit   (out_bit),
        .out_last  (out_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compute_parity();
        bit p = 1'b0;
        for (int i = 0; i < M; i++) begin
            bit s = 1'b0;
            for (int e = 0; e < 5; e++) begin
                if (conn[i][e] >= 0) s ^= dat[conn[i][e]];
            end
            p ^= s;
            par[i] = p;
        end
    endtask

    // One cycle: drive, settle, compare with model, advance model.
    task automatic step(input bit iv, input bit ib, input bit ordy);
        bit exp_ov, exp_ir, exp_bit, exp_last;
        @(negedge clk);
        in_valid = iv;
        in_bit = ib;
        out_ready = ordy;
        #1;
        exp_ov = (emitted < K) ? iv : 1'b1;
        exp_ir = (emitted < K) ? ordy : 1'b0;
        check(out_valid == exp_ov, "R2 out_valid", out_valid, exp_ov);
        check(in_ready == exp_ir, "R5 in_ready", in_ready, exp_ir);
        last_in_taken = 1'b0;
        if (exp_ov) begin
            exp_last = (emitted == N - 1);
            check(out_last == exp_last, "R2 out_last", out_last, exp_last);
            if (emitted < K) begin
                check(out_bit == ib, "R1 data pass-through", out_bit, ib);
            end else begin
                exp_bit = par[emitted - K];
                if (emitted == K) check(out_bit == exp_bit, "R3 first parity", out_bit, exp_bit);
                else check(out_bit == exp_bit, "R4 chained parity", out_bit, exp_bit);
                if (prev_stall) check(out_bit == prev_bit, "R6 stalled bit held", out_bit, prev_bit);
            end
        end else begin
            check(out_last == 1'b0, "R2 out_last idle", out_last, 0);
        end
        prev_stall = (emitted >= K) && !ordy;
        prev_bit = out_bit;
        if (exp_ov && ordy) begin
            if (emitted < K) begin
                dat[emitted] = ib;
                last_in_taken = 1'b1;
                if (emitted == K - 1) compute_parity();
            end else begin
                got[emitted - K] = out_bit;
            end
            emitted++;
            if (emitted == N) begin
                emitted = 0;
                frames++;
            end
        end
    endtask

    // Send one frame with given valid/ready percentages.
    task automatic run_frame(input logic [K-1:0] data, input int vprob, input int rprob);
        int idx = 0;
        int start = frames;
        int outs = 0;
        while (frames == start) begin
            bit iv = (idx < K) && (($urandom % 100) < vprob);
            bit ib = iv ? data[idx] : 1'($urandom);
            bit rd = (($urandom % 100) < rprob);
            step(iv, ib, rd);
            if (out_valid && rd) outs++;
            if (last_in_taken) idx++;
        end
        check(outs == N, "R9 bits per codeword", outs, N);
    endtask

    // Single-bit frame: parity flips must equal the bit's check count.
    task automatic degree_frame(input int j);
        logic [K-1:0] d = '0;
        int flips = 0;
        int exp_deg;
        bit prevp = 1'b0;
        d[j] = 1'b1;
        run_frame(d, 80, 70);
        for (int i = 0; i < M; i++) begin
            if (got[i] != prevp) flips++;
            prevp = got[i];
        end
        exp_deg = (j < 4) ? 3 : 2;
        check(flips == exp_deg, "R8 data bit degree", flips, exp_deg);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", frames, -1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
        end
        @(negedge clk);
        rst_n = 1'b1;
        out_ready = 1'b1;
        #1;
        // R7: reset state.
        check(out_valid == 1'b0, "R7 reset out_valid", out_valid, 0);
        check(out_last == 1'b0, "R7 reset out_last", out_last, 0);
        check(in_ready == 1'b1, "R7 reset in_ready", in_ready, 1);

        run_frame(12'h000, 100, 100);
        run_frame(12'hFFF, 100, 100);
        run_frame(12'h5A3, 60, 50);
        degree_frame(0);
        degree_frame(3);
        degree_frame(4);
        degree_frame(11);
        for (int f = 0; f < 30; f++) begin
            run_frame(12'($urandom), 20 + (f * 3) % 80, 15 + (f * 7) % 85);
        end
        // Long stall on the final parity bit, then a fresh frame.
        for (int i = 0; i < K + M - 1; i++) step(emitted < K, 1'b1, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        check(emitted == 0, "R5 frame closed after last", emitted, 0);
        run_frame(12'h0F0, 100, 100);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule